// File: doc/BRIEF.md
# Instruction Cycle-Compatibility Throttle

This block sits beside the next-instruction fetch path of a microsequenced CPU core clocked at 100 MHz. It can make the core finish instructions no faster than the legacy 4.77 MHz processor it replaces. It derives a 4.77 MHz-rate tick from the core clock and counts those ticks from the moment an instruction begins. When the sequencer reports that the instruction is done, it compares the count with the legacy cycle count for that instruction. If the count is short, it raises a stall that holds off the next fetch until enough ticks have passed.

Throttling is on after reset, so timing-sensitive self-test code sees legacy speed. The first rising edge on the non-maskable interrupt input turns throttling off. It stays off until the next reset, so later code runs at full core speed. Any stall still pending when throttling turns off is released.

Top module: `cycle_throttle`

## Requirements
- R1: A phase accumulator adds 477 every clock and wraps modulo 10000. The tick is high in each cycle whose update wraps. Ticks therefore come 20 or 21 cycles apart, and there are never two in consecutive cycles.
- R2: With throttling on, if the effective tick count at `inst_done` is below the target, `stall` goes high in the cycle after `inst_done`.
- R3: With throttling off, `stall` is low in every cycle, including the cycle right after `inst_done`.
- R4: After reset, `compat_on` is 1 and `stall` is 0, and the accumulator starts from zero.
- R5: `nmi_in` passes through a two-flop synchronizer, and its rising edge is detected. `compat_on` falls at the third clock edge after `nmi_in` rises. It then stays 0 through any further NMI activity until reset.
- R6: The effective count is the number of ticks in the cycles after the `inst_start` cycle, up to and including the `inst_done` cycle. A tick in the `inst_start` cycle itself is not counted. If this count is at least the target, no stall occurs, so a target of 0 never stalls.
- R7: A pending stall falls at the clock edge that ends the tick cycle in which the elapsed count reaches the target.
- R8: A detected NMI edge releases a pending stall at the same clock edge where `compat_on` falls.
- R9: The elapsed tick count saturates at 255 instead of wrapping. After a very long instruction, a target of 255 therefore causes no stall.
- R10: `inst_cycles` is sampled only in the `inst_done` cycle. Changing it while a stall is pending does not change the release cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock (100 MHz nominal) |
| rst | input | 1 | Synchronous active-high reset |
| nmi_in | input | 1 | Asynchronous non-maskable interrupt request |
| inst_start | input | 1 | One-cycle pulse when an instruction begins |
| inst_done | input | 1 | One-cycle pulse when the sequencer finishes an instruction |
| inst_cycles | input | 8 | Legacy cycle count of the finishing instruction, valid with `inst_done` |
| stall | output | 1 | High while the next fetch must wait |
| compat_on | output | 1 | 1 while legacy-timing throttling is active |

## Verification
Two functions can act in the same cycle: the tick-driven release of a pending stall, and the NMI-driven mode switch that also releases it. The bench raises `nmi_in` partway through a long stall. It expects `stall` and `compat_on` to fall together at the third edge, with the stall still high one edge earlier. Separately, a tick that lands in the `inst_done` cycle must count toward the target. The bench's own accumulator model predicts each tick cycle, so the exact release cycle is judged for several gap and target mixes.

// File: rtl/throttle_pkg.sv
package throttle_pkg;

    // Tick generation: INC/MOD of the core clock rate
    localparam int TICK_INC = 477;
    localparam int TICK_MOD = 10000;
    localparam int ACC_W    = $clog2(TICK_MOD + TICK_INC);

    // Width of the legacy cycle count and the elapsed counter
    localparam int CNT_W    = 8;

    typedef enum logic {
        MODE_FAST   = 1'b0,
        MODE_COMPAT = 1'b1
    } thr_mode_e;

    typedef struct packed {
        logic [CNT_W-1:0] elapsed;
        logic [CNT_W-1:0] target;
    } thr_track_t;

    // Saturating increment of the elapsed counter
    function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
        return (v == {CNT_W{1'b1}}) ? v : v + 1'b1;
    endfunction

endpackage

// File: rtl/thr_tick_gen.sv
module thr_tick_gen
    import throttle_pkg::*;
#(
    parameter int INC = TICK_INC,
    parameter int MOD = TICK_MOD
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int W = $clog2(MOD + INC);
    localparam logic [W-1:0] INC_W = W'(INC);
    localparam logic [W-1:0] MOD_W = W'(MOD);

    logic [W-1:0] acc_q;
    logic [W-1:0] sum;
    logic [W-1:0] acc_d;

    always_comb begin
        sum   = acc_q + INC_W;
        tick  = (sum >= MOD_W);
        acc_d = tick ? (sum - MOD_W) : sum;
    end

    always_ff @(posedge clk) begin
        if (rst) acc_q <= '0;
        else     acc_q <= acc_d;
    end

    AST_ACC_BELOW_MOD: assert property (@(posedge clk) disable iff (rst)
        acc_q < MOD_W);                                     // R1

    AST_TICK_SPACED: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);                                    // R1

endmodule

// File: rtl/thr_mode_latch.sv
module thr_mode_latch
    import throttle_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      nmi_async,
    output logic      nmi_rise,
    output thr_mode_e mode
);
    logic s1_q, s2_q, s3_q;
    thr_mode_e mode_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q <= 1'b0;
            s2_q <= 1'b0;
            s3_q <= 1'b0;
        end else begin
            s1_q <= nmi_async;
            s2_q <= s1_q;
            s3_q <= s2_q;
        end
    end

    assign nmi_rise = s2_q & ~s3_q;

    always_ff @(posedge clk) begin
        if (rst)           mode_q <= MODE_COMPAT;
        else if (nmi_rise) mode_q <= MODE_FAST;
    end

    assign mode = mode_q;

    AST_MODE_STICKY: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_FAST) |=> (mode_q == MODE_FAST));   // R5

endmodule

// File: rtl/thr_wait_ctrl.sv
module thr_wait_ctrl
    import throttle_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             compat,
    input  logic             clear,
    input  logic             inst_start,
    input  logic             inst_done,
    input  logic [CNT_W-1:0] inst_cycles,
    output logic             stall
);
    thr_track_t       trk_q, trk_d;
    logic             stall_q, stall_d;
    logic [CNT_W-1:0] eff;

    always_comb begin
        eff     = tick ? sat_inc(trk_q.elapsed) : trk_q.elapsed;
        trk_d   = trk_q;
        stall_d = stall_q;

        if (inst_start) trk_d.elapsed = '0;
        else            trk_d.elapsed = eff;

        if (inst_done) begin
            trk_d.target = inst_cycles;
            stall_d      = compat && !clear && (eff < inst_cycles);
        end else if (stall_q) begin
            if (!compat || clear)        stall_d = 1'b0;
            else if (eff >= trk_q.target) stall_d = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            trk_q   <= '0;
            stall_q <= 1'b0;
        end else begin
            trk_q   <= trk_d;
            stall_q <= stall_d;
        end
    end

    assign stall = stall_q;

    AST_RELEASE_AT_TARGET: assert property (@(posedge clk) disable iff (rst)
        $fell(stall_q) |-> (trk_q.elapsed >= trk_q.target || !compat)); // R7

    AST_FAST_NO_STALL: assert property (@(posedge clk) disable iff (rst)
        !compat |=> !stall_q);                              // R3

    AST_STALL_NEEDS_DONE: assert property (@(posedge clk) disable iff (rst)
        $rose(stall_q) |-> $past(inst_done));               // R2

    AST_CLEAR_RELEASES: assert property (@(posedge clk) disable iff (rst)
        clear |=> !stall_q);                                // R8

endmodule

// File: rtl/cycle_throttle.sv
module cycle_throttle
    import throttle_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             nmi_in,
    input  logic             inst_start,
    input  logic             inst_done,
    input  logic [CNT_W-1:0] inst_cycles,
    output logic             stall,
    output logic             compat_on
);
    logic      tick;
    logic      nmi_rise;
    thr_mode_e mode;

    thr_tick_gen #(
        .INC (TICK_INC),
        .MOD (TICK_MOD)
    ) u_tick (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    thr_mode_latch u_mode (
        .clk       (clk),
        .rst       (rst),
        .nmi_async (nmi_in),
        .nmi_rise  (nmi_rise),
        .mode      (mode)
    );

    thr_wait_ctrl u_wait (
        .clk         (clk),
        .rst         (rst),
        .tick        (tick),
        .compat      (mode == MODE_COMPAT),
        .clear       (nmi_rise),
        .inst_start  (inst_start),
        .inst_done   (inst_done),
        .inst_cycles (inst_cycles),
        .stall       (stall)
    );

    assign compat_on = (mode == MODE_COMPAT);

endmodule

// File: tb/cycle_throttle_bench.sv
module cycle_throttle_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       nmi_in = 1'b0;
    logic       inst_start = 1'b0;
    logic       inst_done = 1'b0;
    logic [7:0] inst_cycles = '0;
    logic       stall;
    logic       compat_on;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    int bacc = 0;

    always #4 clk = ~clk;

    cycle_throttle u_cycle_throttle (
        .clk(clk), .rst(rst), .nmi_in(nmi_in), .inst_start(inst_start),
        .inst_done(inst_done), .inst_cycles(inst_cycles),
        .stall(stall), .compat_on(compat_on)
    );

    // Reference accumulator from R1
    always @(posedge clk) begin
        if (rst) bacc <= 0;
        else     bacc <= (bacc + 477) % 10000;
    end

    function automatic bit btick();
        return (bacc + 477) >= 10000;
    endfunction

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        nmi_in = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R4", "stall after reset", int'(stall), 0);
        check("R4", "compat_on after reset", int'(compat_on), 1);
    endtask

    // One instruction: start, gap cycles, done with target; checks release cycle.
    task automatic run_instr(string req, int gap, int tgt, bit exp_compat,
                             bit scramble, output int waits);
        int cnt = 0;
        waits = 0;
        inst_start = 1'b1;
        @(negedge clk);
        inst_start = 1'b0;
        for (int i = 0; i < gap; i++) begin
            if (btick() && cnt < 255) cnt++;
            @(negedge clk);
        end
        inst_done = 1'b1;
        inst_cycles = 8'(tgt);
        if (btick() && cnt < 255) cnt++;
        @(negedge clk);
        inst_done = 1'b0;
        if (scramble) inst_cycles = ~8'(tgt);
        check(req, "stall after done", int'(stall), (exp_compat && cnt < tgt) ? 1 : 0);
        if (exp_compat) begin
            while (cnt < tgt) begin
                if (stall !== 1'b1) begin
                    check(req, "stall held while short", int'(stall), 1);
                    break;
                end
                if (btick()) cnt++;
                @(negedge clk);
                waits++;
            end
        end
        check(req, "stall released on target tick", int'(stall), 0);
    endtask

    task automatic t_basic();
        int w;
        run_instr("R2", 0, 5, 1, 0, w);
        run_instr("R7", 3, 12, 1, 0, w);
        run_instr("R7", 37, 4, 1, 0, w);
    endtask

    task automatic t_enough();
        int w;
        run_instr("R6", 100, 3, 1, 0, w);
        check("R6", "no wait when count met", w, 0);
        run_instr("R6", 0, 0, 1, 0, w);
        check("R6", "target zero never waits", w, 0);
    endtask

    task automatic t_rate();
        int w;
        run_instr("R1", 0, 21, 1, 0, w);
        checks++;
        if (w < 395 || w > 445) begin
            errors++;
            $display("FAIL R1 wait span for 21 ticks: actual %0d expected 395..445", w);
        end
    endtask

    task automatic t_sample();
        int w;
        run_instr("R10", 0, 6, 1, 1, w);
        run_instr("R10", 2, 9, 1, 1, w);
    endtask

    task automatic t_saturate();
        int w;
        run_instr("R9", 6000, 255, 1, 0, w);
        check("R9", "saturated count meets 255", w, 0);
    endtask

    task automatic t_nmi_during_stall();
        inst_start = 1'b1;
        @(negedge clk);
        inst_start = 1'b0;
        inst_done = 1'b1;
        inst_cycles = 8'd200;
        @(negedge clk);
        inst_done = 1'b0;
        repeat (5) @(negedge clk);
        check("R2", "long stall pending", int'(stall), 1);
        nmi_in = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R5", "compat still on after two edges", int'(compat_on), 1);
        check("R8", "stall still on after two edges", int'(stall), 1);
        @(negedge clk);
        check("R5", "compat off at third edge", int'(compat_on), 0);
        check("R8", "stall released with mode clear", int'(stall), 0);
    endtask

    task automatic t_fast();
        int w;
        run_instr("R3", 0, 150, 0, 0, w);
        repeat (4) begin
            @(negedge clk);
            check("R3", "stall stays low in fast mode", int'(stall), 0);
        end
        nmi_in = 1'b0;
        repeat (4) @(negedge clk);
        nmi_in = 1'b1;
        repeat (6) @(negedge clk);
        check("R5", "compat stays off after second NMI", int'(compat_on), 0);
        nmi_in = 1'b0;
    endtask

    initial begin
        do_reset();
        t_basic();
        t_enough();
        t_rate();
        t_sample();
        t_saturate();
        t_nmi_during_stall();
        t_fast();
        do_reset();
        t_basic();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule